// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a word stream by a fixed number of clock-enabled steps. The words are held in a dual-port storage array, not in a chain of flip-flops. On every enabled cycle, one word enters the array at a write position and one word leaves it at a read position. Only these two positions advance; the stored data never moves. The block is used wherever a long, fixed pipeline delay is needed, such as aligning one data path with a slower parallel path. At that length a register chain would cost far more area.

There is no address input. A read counter starts at the first entry and a write counter starts at the last entry. Both step once per enabled cycle and wrap at the array size. The result is a delay of exactly DEPTH enabled cycles, with a registered output. While the enable is low, the block freezes completely. The output is unspecified until DEPTH words have been written after reset.

Top module: `ramdelay_line`

## Requirements
- R1: While `rst_n` is low, `dout` is all zeros. The output clears as soon as `rst_n` falls, without waiting for a clock edge.
- R2: Number the enabled clock edges since reset 1, 2, 3 and so on. Once at least DEPTH of them have occurred, `dout` after enabled edge k carries the `din` word sampled at enabled edge k-DEPTH+1. This is the same behaviour as a DEPTH-stage register chain advanced only on enabled edges.
- R3: A rising clock edge with `en` low leaves `dout` unchanged.
- R4: A word on `din` during a cycle with `en` low is never stored. It never appears on `dout`, and the enabled words keep their R2 order.
- R5: The read and write positions wrap modulo DEPTH (a power of two, at least 2). The R2 relation holds without a break over any number of wraps.
- R6: A reset applied mid-stream discards all history. The R2 numbering restarts from the first enabled edge after `rst_n` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| en | input | 1 | Advance enable: when high, write one word, read one word, and step both positions |
| din | input | WIDTH | Word entering the delay line |
| dout | output | WIDTH | Word leaving the delay line, registered |

## Verification
The bench builds two copies side by side, both with WIDTH 8, one with DEPTH 8 and one with DEPTH 2, and drives them from the same stimulus. The depth-2 copy reaches the tightest case, where the read and write positions swap every enabled cycle. The depth-8 copy wraps dozens of times within a few hundred cycles, so R5 is covered heavily. One recorded history of enabled inputs gives the expected output of each copy by index arithmetic alone. Enable patterns run from continuous, to a periodic stall, to random stalls with marker values on `din`, and an asynchronous reset falls mid-stream.

// File: rtl/ramdelay_pkg.sv
package ramdelay_pkg;

  // True when v is a power of two and at least 2.
  function automatic bit depth_ok(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction

  // Position loaded into a counter at reset: first or last entry.
  typedef enum logic { START_FIRST = 1'b0, START_LAST = 1'b1 } start_e;

endpackage

// File: rtl/ramdelay_ptr.sv
module ramdelay_ptr
  import ramdelay_pkg::*;
#(
  parameter int     AW    = 8,
  parameter start_e START = START_FIRST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] INIT = (START == START_LAST) ? {AW{1'b1}} : {AW{1'b0}};

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;

  // Next position; wraps naturally because the depth equals 2**AW.
  always_comb begin
    ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= INIT;
    end else if (adv) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/ramdelay_mem.sv
module ramdelay_mem #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] rd_q;
  logic [WIDTH-1:0] rd_d;

  // Storage array: written only, never reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

  // Synchronous read port with its own output register.
  always_comb begin
    rd_d = store[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/ramdelay_line.sv
module ramdelay_line
  import ramdelay_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int AW = $clog2(DEPTH);

  generate
    if (!depth_ok(DEPTH)) begin : g_bad_depth
      $error("ramdelay_line: DEPTH must be a power of two and at least 2");
    end
  endgenerate

  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] wr_ptr;

  // Read position starts at the first entry.
  ramdelay_ptr #(.AW(AW), .START(START_FIRST)) u_rd_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (en),
    .ptr   (rd_ptr)
  );

  // Write position starts at the last entry, one behind the reader.
  ramdelay_ptr #(.AW(AW), .START(START_LAST)) u_wr_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (en),
    .ptr   (wr_ptr)
  );

  ramdelay_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (en),
    .wr_addr (wr_ptr),
    .wr_data (din),
    .rd_en   (en),
    .rd_addr (rd_ptr),
    .rd_data (dout)
  );

endmodule

// File: rtl/ramdelay_line_chk.sv
module ramdelay_line_chk #(
  parameter int AW    = 8,
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [WIDTH-1:0] dout,
  input logic [AW-1:0]    rd_ptr,
  input logic [AW-1:0]    wr_ptr
);

  // R1: output held at zero across any edge seen during reset.
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (dout == '0);
    end
  end

  // R2: writer trails reader by exactly one entry, modulo the depth.
  p_ptr_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(rd_ptr - wr_ptr) == AW'(1));

  // R3: a disabled edge leaves the output unchanged.
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));

  // R4: a disabled edge moves neither position, so nothing is written.
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(rd_ptr) && $stable(wr_ptr)));

  // R5: an enabled edge steps the read position by one, with wrap.
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> rd_ptr == AW'($past(rd_ptr) + AW'(1)));

endmodule

bind ramdelay_line ramdelay_line_chk #(.AW(AW), .WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .dout   (dout),
  .rd_ptr (rd_ptr),
  .wr_ptr (wr_ptr)
);

// File: tb/ramdelay_line_bench.sv
module ramdelay_line_bench;

  localparam int W    = 8;
  localparam int DA   = 8;
  localparam int DB   = 2;
  localparam int MAXH = 4096;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic         rst_n;
  logic         en;
  logic [W-1:0] din;
  logic [W-1:0] dout_a;
  logic [W-1:0] dout_b;

  ramdelay_line #(.WIDTH(W), .DEPTH(DA)) u_ramdelay_line (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dout_a));

  ramdelay_line #(.WIDTH(W), .DEPTH(DB)) u_ramdelay_line_b (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dout_b));

  int           checks = 0;
  int           fails  = 0;
  int           n      = 0;
  bit           done   = 1'b0;
  logic [W-1:0] hist [MAXH];
  logic [W-1:0] prev_a;
  logic [W-1:0] prev_b;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Drive one cycle, then check both outputs 1 ns after the edge.
  task automatic step(input bit e, input logic [W-1:0] d, input string req);
    en     = e;
    din    = d;
    prev_a = dout_a;
    prev_b = dout_b;
    @(posedge clk);
    #1;
    if (e) begin
      if (n < MAXH) hist[n] = d;
      n++;
      if (n >= DA) check({req, " depth8"}, dout_a, hist[n - DA]);
      if (n >= DB) check({req, " depth2"}, dout_b, hist[n - DB]);
    end else begin
      check("R3 hold depth8", dout_a, prev_a);
      check("R3 hold depth2", dout_b, prev_b);
    end
  endtask

  initial begin
    rst_n = 1'b1;
    en    = 1'b0;
    din   = '0;
    #2 rst_n = 1'b0;
    #1;
    check("R1 async clear depth8", dout_a, '0);
    check("R1 async clear depth2", dout_b, '0);
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R1 held depth8", dout_a, '0);
    check("R1 held depth2", dout_b, '0);
    rst_n = 1'b1;

    // R2 and R5: continuous stream, many wraps of both depths.
    for (int i = 0; i < 200; i++) step(1'b1, W'(i * 37 + 11), "R2");

    // R4: periodic stalls carrying marker words that must never appear.
    for (int i = 0; i < 300; i++) begin
      if (i % 3 == 0) step(1'b0, W'(8'hA5 ^ i), "R4");
      else            step(1'b1, W'(i * 53 + 7), "R4");
    end

    // R5: random stalls and random data over many more wraps.
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, W'($urandom), "R5");
    end

    // R6 and R1: reset mid-stream, between clock edges.
    #3 rst_n = 1'b0;
    #1;
    check("R1 mid-stream clear depth8", dout_a, '0);
    check("R1 mid-stream clear depth2", dout_b, '0);
    n = 0;
    @(posedge clk);
    #1;
    check("R6 reset held depth8", dout_a, '0);
    check("R6 reset held depth2", dout_b, '0);
    rst_n = 1'b1;

    // R6: refill after reset; the first post-reset word leads the sequence.
    for (int i = 0; i < 100; i++) begin
      if (i % 5 == 4) step(1'b0, W'(8'h3C + i), "R6");
      else            step(1'b1, W'(i * 29 + 101), "R6");
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule